// File: doc/BRIEF.md
# Byte-Wide SRAM Slave Port

This block is a clock-sampled model of an 8192 x 8 static memory with active-low asynchronous-style controls: chip select (`sel_n`), write strobe (`wr_n`) and output enable (`oe_n`). It takes a 13-bit address. The bidirectional data bus is split into `wdata`, `rdata` and a drive-enable `rdata_oe`. All control inputs are sampled on the rising clock edge. Every delay is a whole number of cycles.

A write window is open while both `sel_n` and `wr_n` are low. Either signal can open the window, and either can close it. The byte captured on the last open edge is stored at the edge where the window is first seen closed. A read drives the bus when `sel_n` and `oe_n` are low and `wr_n` is high. The data appears after a configurable number of stable cycles.

A `protect` input from a power supervisor overrides everything. It blanks the outputs and cancels any pending store, and the stored contents are kept. An address that moves inside a write window sets a flag, and the store then goes to the final address.

Top module: `sram_byte_port`

## Requirements
- R1: After reset, `rdata_oe` and `addr_err` are 0 and `rdata` is 0.
- R2: The byte committed is `wdata` as sampled at the last edge where `sel_n`=0, `wr_n`=0 and `protect`=0. It is written at the first edge where `sel_n` or `wr_n` is sampled high, and a later value of `wdata` overwrites an earlier one within the same window.
- R3: The window can be opened and closed by `wr_n` pulsing while `sel_n` is held low, and also by `sel_n` pulsing while `wr_n` is held low.
- R4: A read is requested at an edge where `sel_n`=0, `oe_n`=0, `wr_n`=1 and `protect`=0. `rdata_oe` goes to 1 after the RD_LAT-th consecutive such edge with an unchanged address (RD_LAT=2 by default), and `rdata` then carries the stored byte.
- R5: A change of address during a read restarts the RD_LAT count.
- R6: An edge with `wr_n`=0 leaves `rdata_oe` at 0 after that edge, even when `sel_n` and `oe_n` are both 0. `rdata` reads 0 whenever `rdata_oe` is 0.
- R7: An address change between two edges of one open window sets `addr_err` after the second edge. The store then goes to the final address, and the first address is left unchanged. `addr_err` stays set until the edge that opens the next window.
- R8: While `protect` is 1, no commit takes place, even if the window closes, and `rdata_oe` is 0 after the edge. Contents written earlier are kept.
- R9: All 13 address bits select distinct bytes, including address 0x0000 and address 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of control state |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data from the bus |
| protect | input | 1 | Supervisor write/output inhibit |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Bus drive enable |
| addr_err | output | 1 | Address moved inside a write window |

## Verification
The bench drives both kinds of window, one controlled by the write strobe and one by chip select. The two must store the same data, which shows that the window is formed by the overlap of the two signals and not by one of them. It also drives a window whose data changes, a window whose address moves and a window cut by protect. These patterns separate capture at the close of the window from capture at its opening, and a real commit from a suppressed one. Reads are tried at the two ends of the address range, with an address change part-way through and with `wr_n` low while `sel_n` and `oe_n` are low. These show the exact latency, the restart of the latency count and the blanking rule.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  localparam int unsigned ADDR_W_DEF = 13;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned RD_LAT_DEF = 2;

  // chip selected and write strobe low: write overlap
  function automatic logic wr_overlap(input logic sel_n, input logic wr_n);
    return !sel_n && !wr_n;
  endfunction

  // output drive is requested only with the write strobe high
  function automatic logic rd_wanted(input logic sel_n, input logic wr_n,
                                     input logic oe_n);
    return !sel_n && !oe_n && wr_n;
  endfunction
endpackage

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overlap,
  input  logic              protect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              win_open,
  output logic              addr_slip,
  output logic              addr_err
);
  logic              open_q;
  logic              open_now;
  logic              win_start;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  assign open_now  = overlap && !protect;
  assign win_start = open_now && !open_q;
  assign addr_slip = open_now && open_q && (addr != addr_q);
  assign commit    = open_q && !overlap && !protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_now;
      if (open_now) begin
        addr_q <= addr;
        data_q <= wdata;
      end
      if (win_start)      err_q <= 1'b0;
      else if (addr_slip) err_q <= 1'b1;
    end
  end

  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign win_open = open_q;
  assign addr_err = err_q;
endmodule

// File: rtl/sram_rd_timer.sv
module sram_rd_timer #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready_nxt,
  output logic              ready
);
  localparam int unsigned CW = $clog2(RD_LAT + 1);
  localparam logic [CW-1:0] LIM = CW'(RD_LAT);

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nxt;
  logic [ADDR_W-1:0] last_q;
  logic              ready_q;

  always_comb begin
    if (!rd_req)                               cnt_nxt = '0;
    else if (cnt_q == '0 || addr != last_q)    cnt_nxt = CW'(1);
    else if (cnt_q == LIM)                     cnt_nxt = LIM;
    else                                       cnt_nxt = cnt_q + CW'(1);
  end

  assign ready_nxt = rd_req && (cnt_nxt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      last_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      last_q  <= addr;
      ready_q <= ready_nxt;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_take,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] fwd;

  // a store and a read of the same byte at one edge return the new byte
  assign fwd = (we && waddr == raddr) ? wdata : mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_take) rdata_q <= fwd;
    else              rdata_q <= '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sram_byte_port.sv
module sram_byte_port
  import sram_port_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned RD_LAT = RD_LAT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              protect,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              addr_err
);
  logic              overlap;
  logic              rd_req;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              win_open;
  logic              addr_slip;
  logic              ready_nxt;

  assign overlap = wr_overlap(sel_n, wr_n);
  assign rd_req  = rd_wanted(sel_n, wr_n, oe_n) && !protect;

  sram_wr_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) win_i (
    .clk(clk), .rst_n(rst_n), .overlap(overlap), .protect(protect),
    .addr(addr), .wdata(wdata), .commit(commit), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_open(win_open), .addr_slip(addr_slip),
    .addr_err(addr_err)
  );

  sram_rd_timer #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) tmr_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr),
    .ready_nxt(ready_nxt), .ready(rdata_oe)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_addr),
    .wdata(wr_data), .rd_take(ready_nxt), .raddr(addr), .rdata(rdata)
  );
endmodule

// File: rtl/sram_byte_port_chk.sv
module sram_byte_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic              protect,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              addr_err,
  input logic              commit,
  input logic              win_open,
  input logic              addr_slip
);
  // R6
  we_low_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> !rdata_oe);
  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);
  // R8
  protect_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protect |=> !rdata_oe);
  // R8
  protect_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> !commit);
  // R4
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(!sel_n && !oe_n && wr_n && !protect));
  // R7
  err_from_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |-> $past(addr_slip));
  // R2
  commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> win_open && !(!sel_n && !wr_n));
endmodule

bind sram_byte_port sram_byte_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
  .protect(protect), .rdata(rdata), .rdata_oe(rdata_oe),
  .addr_err(addr_err), .commit(commit), .win_open(win_open),
  .addr_slip(addr_slip)
);

// File: tb/sram_byte_port_tb.sv
module sram_byte_port_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, protect = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, addr_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  sram_byte_port #(.RD_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .protect(protect), .rdata(rdata),
    .rdata_oe(rdata_oe), .addr_err(addr_err)
  );

  // behavioural reference
  byte unsigned ref_mem [int];
  bit   m_open = 0, m_err = 0, m_en = 0, m_known = 0;
  int   m_waddr = 0, m_wdata = 0, m_last = -1, m_run = 0;
  byte unsigned m_dout = 0;

  always @(posedge clk) begin
    bit overlap, rd;
    overlap = !sel_n && !wr_n;
    rd = !sel_n && !oe_n && wr_n && !protect;
    if (!rst_n) begin
      m_open = 0; m_err = 0; m_en = 0; m_run = 0; m_last = -1; m_dout = 0;
    end else begin
      if (m_open && !overlap && !protect) ref_mem[m_waddr] = 8'(m_wdata);
      if (overlap && !protect) begin
        if (!m_open) m_err = 0;
        else if (int'(addr) != m_waddr) m_err = 1;
        m_waddr = int'(addr); m_wdata = int'(wdata); m_open = 1;
      end else m_open = 0;
      if (!rd) m_run = 0;
      else if (int'(addr) != m_last || m_run == 0) m_run = 1;
      else if (m_run < LAT) m_run++;
      m_last = int'(addr);
      m_en = rd && (m_run == LAT);
      m_known = m_en && ref_mem.exists(int'(addr));
      m_dout = m_known ? ref_mem[int'(addr)] : 8'h00;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " drive enable"}, int'(rdata_oe), int'(m_en));
      chk({phase, " addr_err"}, int'(addr_err), int'(m_err));
      if (m_known || !m_en) chk({phase, " rdata"}, int'(rdata), int'(m_dout));
    end
  end

  task automatic step(input bit s, input bit w, input bit o, input int a,
                      input int d, input bit p);
    sel_n = s; wr_n = w; oe_n = o; addr = 13'(a); wdata = 8'(d); protect = p;
    @(negedge clk);
  endtask

  // window opened and closed by the write strobe, chip held selected
  task automatic wr_by_strobe(input int a, input int d);
    step(0, 1, 1, a, 0, 0);
    step(0, 0, 1, a, d, 0);
    step(0, 0, 1, a, d, 0);
    step(0, 1, 1, a, 0, 0);
    step(1, 1, 1, a, 0, 0);
  endtask

  // window opened and closed by chip select, strobe held low
  task automatic wr_by_select(input int a, input int d);
    step(1, 0, 1, a, 0, 0);
    step(0, 0, 1, a, d, 0);
    step(1, 0, 1, a, 0, 0);
    step(1, 1, 1, a, 0, 0);
  endtask

  task automatic rd_check(input string tag, input int a, input int exp);
    for (int i = 1; i < LAT; i++) begin
      step(0, 1, 0, a, 0, 0);
      chk({tag, " early"}, int'(rdata_oe), 0);
    end
    step(0, 1, 0, a, 0, 0);
    chk({tag, " drive"}, int'(rdata_oe), 1);
    chk({tag, " data"}, int'(rdata), exp);
    step(1, 1, 1, a, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset drive", int'(rdata_oe), 0);
    chk("R1 reset err", int'(addr_err), 0);
    chk("R1 reset data", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R3";
    wr_by_strobe(13'h0010, 8'hA5);
    rd_check("R3 strobe window", 13'h0010, 8'hA5);
    wr_by_select(13'h0011, 8'h5A);
    rd_check("R3 select window", 13'h0011, 8'h5A);

    phase = "R9";
    wr_by_strobe(13'h0000, 8'h11);
    wr_by_select(13'h1FFF, 8'h3C);
    rd_check("R9 low end", 13'h0000, 8'h11);
    rd_check("R9 high end", 13'h1FFF, 8'h3C);

    phase = "R2";
    step(0, 1, 1, 13'h0040, 0, 0);
    step(0, 0, 1, 13'h0040, 8'h01, 0);
    step(0, 0, 1, 13'h0040, 8'h02, 0);
    step(0, 1, 1, 13'h0040, 8'hFF, 0);
    step(1, 1, 1, 0, 0, 0);
    rd_check("R2 last data wins", 13'h0040, 8'h02);

    phase = "R6";
    step(1, 0, 0, 13'h0010, 8'hA5, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 13'h0010, 8'hA5, 0);
      chk("R6 strobe low blanks", int'(rdata_oe), 0);
      chk("R6 idle data zero", int'(rdata), 0);
    end
    step(1, 1, 1, 0, 0, 0);

    phase = "R5";
    step(0, 1, 0, 13'h0010, 0, 0);
    step(0, 1, 0, 13'h1FFF, 0, 0);
    chk("R5 restart after move", int'(rdata_oe), 0);
    step(0, 1, 0, 13'h1FFF, 0, 0);
    chk("R5 drive after restart", int'(rdata_oe), 1);
    chk("R5 data after restart", int'(rdata), 8'h3C);
    step(1, 1, 1, 0, 0, 0);

    phase = "R7";
    wr_by_strobe(13'h0020, 8'h01);
    step(0, 1, 1, 13'h0020, 0, 0);
    step(0, 0, 1, 13'h0020, 8'h77, 0);
    chk("R7 no err yet", int'(addr_err), 0);
    step(0, 0, 1, 13'h0021, 8'h77, 0);
    chk("R7 err set", int'(addr_err), 1);
    step(0, 1, 1, 13'h0021, 0, 0);
    step(1, 1, 1, 0, 0, 0);
    chk("R7 err held", int'(addr_err), 1);
    rd_check("R7 final address", 13'h0021, 8'h77);
    rd_check("R7 first address kept", 13'h0020, 8'h01);
    step(0, 1, 1, 13'h0022, 0, 0);
    step(0, 0, 1, 13'h0022, 8'h09, 0);
    chk("R7 err cleared by new window", int'(addr_err), 0);
    step(0, 1, 1, 13'h0022, 0, 0);
    step(1, 1, 1, 0, 0, 0);

    phase = "R8";
    wr_by_strobe(13'h0030, 8'h55);
    step(0, 1, 1, 13'h0030, 0, 0);
    step(0, 0, 1, 13'h0030, 8'hAA, 0);
    step(0, 0, 1, 13'h0030, 8'hAA, 1);
    step(0, 1, 1, 13'h0030, 0, 1);
    step(0, 1, 0, 13'h0030, 0, 1);
    step(0, 1, 0, 13'h0030, 0, 1);
    chk("R8 protect blanks read", int'(rdata_oe), 0);
    step(1, 1, 1, 0, 0, 0);
    rd_check("R8 contents kept", 13'h0030, 8'h55);

    phase = "R4";
    rd_check("R4 latency", 13'h0011, 8'h5A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule